// File: doc/BRIEF.md
# Command-Synchronized Timestamp Counter

This block holds the time-stamp register of one acquisition device on a timing link. Its inputs are timing commands that have already been decoded and a SYNC strobe. A preset command stages a start value and does not start the counter. The next SYNC loads the staged value and starts counting. Every device on the link receives the same broadcast SYNC, so every device starts its counter on the same clock edge.

While the counter runs, verify commands arrive from time to time with an expected time. The block compares that value, corrected by a fixed decode latency, against the running count. On a mismatch it raises a sticky error and captures both the corrected expected value and the actual value. The counter keeps running and is not reloaded. A third command type writes small control registers over the same link.

A strap input sets the device role. In the master role a local SYNC request is taken as a SYNC. In the slave role local requests are ignored, and the block only acts on SYNCs it receives and passes them downstream.

Top module: `sync_timestamp`

## Requirements
- R1: After a synchronous reset the count is 0, the counter is stopped, no preset is pending, `verify_ok` and `verify_err` are 0, the captured values are 0, the stray-SYNC count is 0, every control register is 0 and `sync_out` is 0.
- R2: A preset command (`cmd_op` = 1) stores `cmd_data` as the staged value and sets `preset_pending`. It does not start, load or change the counter.
- R3: An effective SYNC while a preset is pending behaves as follows:
  - `ts_count` equals the staged value after that edge, and `ts_running` is 1.
  - Pending clears, unless a new preset arrives in the same cycle. A preset arriving together with a SYNC is staged, but that SYNC does not use it.
- R4: While running, the count increases by one on every clock that is not a load, and wraps from 2^56-1 to 0.
- R5: An effective SYNC with no preset pending leaves the counter unchanged and adds one to `stray_syncs`, which saturates at 255.
- R6: A verify command (`cmd_op` = 2) is compared on its decode cycle:
  - The comparison is between the count before that edge and `cmd_data` + 2, modulo 2^56.
  - On equality, `verify_ok` is 1 for the following cycle only.
- R7: On a verify mismatch while running, `verify_err` is set and stays set until reset. The first mismatch captures `cmd_data` + 2 into `err_expected` and the count into `err_actual`, and later mismatches do not overwrite them. The counter keeps counting.
- R8: A verify command while the counter is stopped has no effect: no `verify_ok` pulse and no change to the error state.
- R9: The effective SYNC is `sync_in` OR (`role_master` AND `local_sync_req`). `sync_out` repeats the effective SYNC one cycle later. In the slave role, `local_sync_req` has no effect on the counter, on `stray_syncs` or on `sync_out`.
- R10: A control write (`cmd_op` = 3) writes `cmd_data[15:0]` into control register `cmd_data[17:16]`. Register k appears at `ctrl_regs[16k+15:16k]` one cycle later.
- R11: A preset while the counter runs does not disturb counting. The new value is loaded on the next effective SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| sync_in | input | 1 | SYNC strobe received from the link |
| local_sync_req | input | 1 | Locally requested SYNC, honoured in the master role only |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 2 | 0 none, 1 preset, 2 verify, 3 control write |
| cmd_data | input | 56 | Command payload |
| sync_out | output | 1 | Registered effective SYNC for downstream |
| ts_count | output | 56 | Time-stamp count |
| ts_running | output | 1 | Counter running |
| preset_pending | output | 1 | Staged value waiting for a SYNC |
| verify_ok | output | 1 | One-cycle pulse on a matching verify |
| verify_err | output | 1 | Sticky verify mismatch flag |
| err_expected | output | 56 | Corrected expected value of the first mismatch |
| err_actual | output | 56 | Count value at the first mismatch |
| stray_syncs | output | 8 | Saturating count of SYNCs with nothing pending |
| ctrl_regs | output | 64 | Four 16-bit control registers, register k at bits 16k+15:16k |

## Verification
The assertions assume that the inputs are stable across each rising edge and known from the end of reset. They also assume that a command and a SYNC may coincide in any combination, and that role changes only take effect at an edge. The bench drives all inputs on the falling edge, so each edge samples settled values. Random stimulus mixes every pairing of preset, verify, control write, received SYNC and local request in both roles. A reference model, updated on the same edges, predicts every output. Directed sequences cover the following:
- same-cycle preset and SYNC
- wraparound
- verify while stopped
- a second mismatch
- a slave local request while a preset is pending

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    TSC_NOP     = 2'd0,
    TSC_PRESET  = 2'd1,
    TSC_VERIFY  = 2'd2,
    TSC_CTRL_WR = 2'd3
  } tsc_op_e;
endpackage

// File: rtl/tsc_cmd_decode.sv
module tsc_cmd_decode #(
  parameter int TS_W   = 56,
  parameter int CTRL_N = 4,
  parameter int CTRL_W = 16,
  localparam int IDX_W = (CTRL_N > 1) ? $clog2(CTRL_N) : 1
) (
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TS_W-1:0]   cmd_data,
  output logic              preset_stb,
  output logic              verify_stb,
  output logic              ctrl_we,
  output logic [IDX_W-1:0]  ctrl_idx,
  output logic [CTRL_W-1:0] ctrl_val,
  output logic [TS_W-1:0]   payload
);
  import tsc_pkg::*;
  tsc_op_e op;

  always_comb begin
    op         = tsc_op_e'(cmd_op);
    preset_stb = cmd_valid && (op == TSC_PRESET);
    verify_stb = cmd_valid && (op == TSC_VERIFY);
    ctrl_we    = cmd_valid && (op == TSC_CTRL_WR);
    ctrl_val   = cmd_data[CTRL_W-1:0];
    ctrl_idx   = cmd_data[CTRL_W +: IDX_W];
    payload    = cmd_data;
  end
endmodule

// File: rtl/tsc_ctrl_regs.sv
module tsc_ctrl_regs #(
  parameter int CTRL_N = 4,
  parameter int CTRL_W = 16,
  localparam int IDX_W = (CTRL_N > 1) ? $clog2(CTRL_N) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [CTRL_W-1:0]        val,
  output logic [CTRL_N*CTRL_W-1:0] regs
);
  for (genvar k = 0; k < CTRL_N; k++) begin : g_reg
    logic [CTRL_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)                                 r_q <= '0;
      else if (we && (idx == IDX_W'(k)))       r_q <= val;
    end
    assign regs[k*CTRL_W +: CTRL_W] = r_q;

    assert_ctrl_write_R10: assert property (@(posedge clk) disable iff (rst)
      (we && (idx == IDX_W'(k))) |=> (regs[k*CTRL_W +: CTRL_W] == $past(val)));
  end
endmodule

// File: rtl/tsc_sync_gate.sv
module tsc_sync_gate (
  input  logic clk,
  input  logic rst,
  input  logic role_master,
  input  logic sync_in,
  input  logic local_sync_req,
  output logic sync_eff,
  output logic sync_out
);
  always_comb sync_eff = sync_in | (role_master & local_sync_req);

  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else     sync_out <= sync_eff;
  end

  assert_slave_no_inject_R9: assert property (@(posedge clk) disable iff (rst)
    (!role_master && !sync_in) |=> !sync_out);
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int TS_W    = 56,
  parameter int STRAY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               preset_stb,
  input  logic [TS_W-1:0]    preset_val,
  input  logic               sync_eff,
  output logic [TS_W-1:0]    count,
  output logic               running,
  output logic               pending,
  output logic [STRAY_W-1:0] stray
);
  localparam logic [STRAY_W-1:0] STRAY_MAX = '1;
  localparam logic [TS_W-1:0]    ONE       = TS_W'(1);

  logic [TS_W-1:0] stage_q;
  logic            load;

  always_comb load = sync_eff && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      pending <= 1'b0;
      stage_q <= '0;
      stray   <= '0;
    end else begin
      if (load) begin
        count   <= stage_q;
        running <= 1'b1;
      end else if (running) begin
        count   <= count + ONE;
      end
      if (sync_eff && !pending && (stray != STRAY_MAX))
        stray <= stray + STRAY_W'(1);
      if (preset_stb) begin
        stage_q <= preset_val;
        pending <= 1'b1;
      end else if (load) begin
        pending <= 1'b0;
      end
    end
  end

  assert_load_on_sync_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (running && (count == $past(stage_q))));
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (running && !load) |=> (count == $past(count) + ONE));
  assert_no_self_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!running && !load) |=> (!running && $stable(count)));
  assert_stray_bump_R5: assert property (@(posedge clk) disable iff (rst)
    (sync_eff && !pending && (stray != STRAY_MAX)) |=> (stray == $past(stray) + STRAY_W'(1)));
endmodule

// File: rtl/tsc_verify.sv
module tsc_verify #(
  parameter int TS_W       = 56,
  parameter int DECODE_LAT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            verify_stb,
  input  logic [TS_W-1:0] expected,
  input  logic [TS_W-1:0] count,
  input  logic            running,
  output logic            ok,
  output logic            err,
  output logic [TS_W-1:0] err_exp,
  output logic [TS_W-1:0] err_act
);
  localparam logic [TS_W-1:0] LAT_V = TS_W'(DECODE_LAT);

  logic [TS_W-1:0] target;
  logic            check, match;

  always_comb begin
    target = expected + LAT_V;
    check  = verify_stb && running;
    match  = (target == count);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok      <= 1'b0;
      err     <= 1'b0;
      err_exp <= '0;
      err_act <= '0;
    end else begin
      ok <= check && match;
      if (check && !match && !err) begin
        err     <= 1'b1;
        err_exp <= target;
        err_act <= count;
      end
    end
  end

  assert_sticky_err_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && $stable(err_exp) && $stable(err_act)));
  assert_capture_differs_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (err_exp != err_act));
  assert_idle_verify_R8: assert property (@(posedge clk) disable iff (rst)
    (verify_stb && !running) |=> (!ok && ($past(err) == err)));
endmodule

// File: rtl/sync_timestamp.sv
module sync_timestamp #(
  parameter int TS_W       = 56,
  parameter int STRAY_W    = 8,
  parameter int CTRL_N     = 4,
  parameter int CTRL_W     = 16,
  parameter int DECODE_LAT = 2,
  localparam int IDX_W     = (CTRL_N > 1) ? $clog2(CTRL_N) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     role_master,
  input  logic                     sync_in,
  input  logic                     local_sync_req,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [TS_W-1:0]          cmd_data,
  output logic                     sync_out,
  output logic [TS_W-1:0]          ts_count,
  output logic                     ts_running,
  output logic                     preset_pending,
  output logic                     verify_ok,
  output logic                     verify_err,
  output logic [TS_W-1:0]          err_expected,
  output logic [TS_W-1:0]          err_actual,
  output logic [STRAY_W-1:0]       stray_syncs,
  output logic [CTRL_N*CTRL_W-1:0] ctrl_regs
);
  logic              preset_stb, verify_stb, ctrl_we, sync_eff;
  logic [IDX_W-1:0]  ctrl_idx;
  logic [CTRL_W-1:0] ctrl_val;
  logic [TS_W-1:0]   payload;

  tsc_cmd_decode #(.TS_W(TS_W), .CTRL_N(CTRL_N), .CTRL_W(CTRL_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .preset_stb(preset_stb),
    .verify_stb(verify_stb),
    .ctrl_we   (ctrl_we),
    .ctrl_idx  (ctrl_idx),
    .ctrl_val  (ctrl_val),
    .payload   (payload)
  );

  tsc_sync_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .role_master   (role_master),
    .sync_in       (sync_in),
    .local_sync_req(local_sync_req),
    .sync_eff      (sync_eff),
    .sync_out      (sync_out)
  );

  tsc_counter #(.TS_W(TS_W), .STRAY_W(STRAY_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .preset_stb(preset_stb),
    .preset_val(payload),
    .sync_eff  (sync_eff),
    .count     (ts_count),
    .running   (ts_running),
    .pending   (preset_pending),
    .stray     (stray_syncs)
  );

  tsc_verify #(.TS_W(TS_W), .DECODE_LAT(DECODE_LAT)) u_ver (
    .clk       (clk),
    .rst       (rst),
    .verify_stb(verify_stb),
    .expected  (payload),
    .count     (ts_count),
    .running   (ts_running),
    .ok        (verify_ok),
    .err       (verify_err),
    .err_exp   (err_expected),
    .err_act   (err_actual)
  );

  tsc_ctrl_regs #(.CTRL_N(CTRL_N), .CTRL_W(CTRL_W)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .we  (ctrl_we),
    .idx (ctrl_idx),
    .val (ctrl_val),
    .regs(ctrl_regs)
  );

  assert_ok_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    verify_ok |=> !verify_ok || $past(verify_stb));
  assert_preset_keeps_run_R11: assert property (@(posedge clk) disable iff (rst)
    (ts_running && preset_stb) |=> ts_running);
endmodule

// File: tb/sync_timestamp_bench.sv
module sync_timestamp_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        role_master = 1'b0, sync_in = 1'b0, local_sync_req = 1'b0, cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [55:0] cmd_data = '0;
  logic        sync_out, ts_running, preset_pending, verify_ok, verify_err;
  logic [55:0] ts_count, err_expected, err_actual;
  logic [7:0]  stray_syncs;
  logic [63:0] ctrl_regs;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_timestamp u_sync_timestamp (
    .clk(clk), .rst(rst), .role_master(role_master), .sync_in(sync_in),
    .local_sync_req(local_sync_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .sync_out(sync_out), .ts_count(ts_count),
    .ts_running(ts_running), .preset_pending(preset_pending), .verify_ok(verify_ok),
    .verify_err(verify_err), .err_expected(err_expected), .err_actual(err_actual),
    .stray_syncs(stray_syncs), .ctrl_regs(ctrl_regs)
  );

  // reference model
  logic [55:0] m_cnt, m_stage, m_eexp, m_eact;
  logic        m_run, m_pend, m_ok, m_err, m_sout;
  logic [7:0]  m_stray;
  logic [63:0] m_ctrl;

  function automatic logic [55:0] plus_lat(input logic [55:0] v);
    return v + 56'(LAT);
  endfunction

  always @(posedge clk) begin
    logic se, ld;
    se = sync_in | (role_master & local_sync_req);
    if (rst) begin
      m_cnt = '0; m_stage = '0; m_eexp = '0; m_eact = '0; m_run = 0; m_pend = 0;
      m_ok = 0; m_err = 0; m_sout = 0; m_stray = '0; m_ctrl = '0;
    end else begin
      m_ok = 0;
      if (cmd_valid && cmd_op == 2'd2 && m_run) begin
        if (m_cnt == plus_lat(cmd_data)) m_ok = 1;
        else if (!m_err) begin m_err = 1; m_eexp = plus_lat(cmd_data); m_eact = m_cnt; end
      end
      ld = se && m_pend;
      if (ld) begin m_cnt = m_stage; m_run = 1; m_pend = 0; end
      else if (m_run) m_cnt = m_cnt + 56'd1;
      if (se && !ld && m_stray != 8'hFF) m_stray = m_stray + 8'd1;
      if (cmd_valid && cmd_op == 2'd1) begin m_stage = cmd_data; m_pend = 1; end
      if (cmd_valid && cmd_op == 2'd3) m_ctrl[cmd_data[17:16]*16 +: 16] = cmd_data[15:0];
      m_sout = se;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 count", 64'(ts_count), 64'(m_cnt));
    chk("R3 running", 64'(ts_running), 64'(m_run));
    chk("R2 pending", 64'(preset_pending), 64'(m_pend));
    chk("R5 stray", 64'(stray_syncs), 64'(m_stray));
    chk("R6 ok", 64'(verify_ok), 64'(m_ok));
    chk("R7 err", 64'(verify_err), 64'(m_err));
    chk("R7 expected", 64'(err_expected), 64'(m_eexp));
    chk("R7 actual", 64'(err_actual), 64'(m_eact));
    chk("R9 sync_out", 64'(sync_out), 64'(m_sout));
    chk("R10 ctrl", ctrl_regs, m_ctrl);
  endtask

  // drive at negedge, sample at following negedge
  task automatic cyc(input logic si, input logic lr, input logic cv,
                     input logic [1:0] op, input logic [55:0] d);
    sync_in = si; local_sync_req = lr; cmd_valid = cv; cmd_op = op; cmd_data = d;
    @(posedge clk); @(negedge clk);
    check_all();
    sync_in = 0; local_sync_req = 0; cmd_valid = 0; cmd_op = 0; cmd_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [55:0] c0, cap_e;
    void'($urandom(32'd1234));
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 count", 64'(ts_count), 0); chk("R1 running", 64'(ts_running), 0);
    chk("R1 pending", 64'(preset_pending), 0); chk("R1 err", 64'(verify_err), 0);
    chk("R1 stray", 64'(stray_syncs), 0); chk("R1 ctrl", ctrl_regs, 0);
    chk("R1 sync_out", 64'(sync_out), 0); chk("R1 ok", 64'(verify_ok), 0);

    // R2: preset alone does not start
    cyc(0, 0, 1, 2'd1, 56'h12_3456_789A);
    idle(3);
    chk("R2 stopped after preset", 64'(ts_running), 0);
    // R8: verify while stopped ignored
    cyc(0, 0, 1, 2'd2, 56'h0);
    chk("R8 no ok when stopped", 64'(verify_ok), 0);
    chk("R8 no err when stopped", 64'(verify_err), 0);
    // R9: slave local request ignored with preset pending
    cyc(0, 1, 0, 2'd0, '0);
    chk("R9 slave local req no load", 64'(ts_running), 0);
    chk("R9 slave local req no sync_out", 64'(sync_out), 0);
    // R3: received sync loads
    cyc(1, 0, 0, 2'd0, '0);
    chk("R3 loaded value", 64'(ts_count), 64'h12_3456_789A);
    idle(4);
    chk("R4 counted four", 64'(ts_count), 64'h12_3456_789E);
    // R6 matching verify
    cyc(0, 0, 1, 2'd2, m_cnt - 56'(LAT));
    chk("R6 ok pulse", 64'(verify_ok), 1);
    idle(1);
    chk("R6 ok single cycle", 64'(verify_ok), 0);
    // R11 preset while running
    c0 = ts_count;
    cyc(0, 0, 1, 2'd1, 56'hAB);
    chk("R11 still counting", 64'(ts_count), 64'(c0 + 56'd1));
    // R3 sync and new preset in same cycle: loads old stage, new one pending
    cyc(1, 0, 1, 2'd1, 56'hCD);
    chk("R3 loaded earlier stage", 64'(ts_count), 64'hAB);
    chk("R3 same-cycle preset pending", 64'(preset_pending), 1);
    cyc(1, 0, 0, 2'd0, '0);
    chk("R3 second load", 64'(ts_count), 64'hCD);
    // R5 stray sync
    cyc(1, 0, 0, 2'd0, '0);
    chk("R5 stray counted", 64'(stray_syncs), 1);
    // R7 mismatch then second mismatch
    cyc(0, 0, 1, 2'd2, 56'h5);
    cap_e = 56'h5 + 56'(LAT);
    chk("R7 err set", 64'(verify_err), 1);
    chk("R7 expected captured", 64'(err_expected), 64'(cap_e));
    cyc(0, 0, 1, 2'd2, 56'h77);
    chk("R7 first capture kept", 64'(err_expected), 64'(cap_e));
    // R4 wrap
    cyc(0, 0, 1, 2'd1, 56'hFF_FFFF_FFFF_FFFE);
    cyc(1, 0, 0, 2'd0, '0);
    idle(2);
    chk("R4 wrap", 64'(ts_count), 0);
    // R10 control writes
    cyc(0, 0, 1, 2'd3, 56'h2_BEEF);
    chk("R10 reg2", 64'(ctrl_regs[47:32]), 64'hBEEF);
    cyc(0, 0, 1, 2'd3, 56'h0_1234);
    // R9 master local request loads
    role_master = 1;
    cyc(0, 0, 1, 2'd1, 56'h999);
    cyc(0, 1, 0, 2'd0, '0);
    chk("R9 master local load", 64'(ts_count), 64'h999);
    chk("R9 master sync_out", 64'(sync_out), 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [55:0] d;
      logic [1:0]  op;
      if ($urandom_range(0, 99) == 0) role_master = ~role_master;
      op = 2'($urandom_range(0, 3));
      d = {24'($urandom), $urandom};
      if (op == 2'd2 && $urandom_range(0, 1) == 1) d = m_cnt - 56'(LAT);
      cyc($urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
          $urandom_range(0, 3) == 0, op, d);
    end

    // R5 saturation
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, 2'd0, '0);
    chk("R5 saturated", 64'(stray_syncs), 64'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule